// File: doc/BRIEF.md
# GPIO Port with PWM Override

This block controls an 8-bit general-purpose I/O port on a small synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. The port has two registers at consecutive byte addresses: an output-data latch and a direction register. Only bits 3..0 are wired to pads. Bits 7..4 of both registers are storage only.

Each of the four pad bits can be taken over by a pulse-width-modulator channel. The PWM enable and PWM level arrive as plain input signals. While a channel is enabled, it drives the pad value and forces the pad driver on. Otherwise the direction bit and the data latch decide what the pad does.

The block produces a value and an output enable for each pad. A pad's input level is passed through a two-flop synchronizer before the bus can read it.

Top module: `gpio_pwm_port`

## Requirements
- R1: While reset is high, the data latch and the direction register are set to all zeros. With no PWM channel enabled, every pad output enable is then 0.
- R2: Writes take effect at the clock edge on which the write strobe is high. The data latch is at address BASE_ADDR and the direction register at BASE_ADDR+1. A write to any other address leaves both registers unchanged.
- R3: The output enable of pad i (i = 0..3) is 1 when direction bit i is 1 (output) or PWM channel i is enabled, and is 0 otherwise. A direction bit of 0 means high-impedance input.
- R4: The output value of pad i is the PWM level of channel i while that channel is enabled, and data-latch bit i otherwise.
- R5: A read of the data address returns the latched bit for every bit whose direction bit is 1.
- R6: A read of the data address returns the pad level for bits 3..0 whose direction bit is 0. That level is the pad input as it was sampled two clock edges earlier.
- R7: A read of the data address returns 0 for bits 7..4 whose direction bit is 0, whatever was written to them.
- R8: A pad whose direction bit is 0 and whose PWM channel is enabled still reads back its synchronized pad level, not the latch and not the PWM level.
- R9: A read of the direction address returns all eight direction bits as written. Bits 7..4 have no effect on any pad.
- R10: A read of any address other than the two register addresses returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 4 | Pad input levels (asynchronous) |
| pwm_en | input | 4 | PWM channel enables |
| pwm_out | input | 4 | PWM channel levels |
| pin_out | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables |

## Verification
A bus write to the data latch and a PWM takeover of the same pad can fall in one cycle. So can a data read and a PWM enable on a pad that is still an input. The random phase toggles the PWM enables, the direction bits, the pad levels and writes to both registers independently on every cycle, so these combinations occur often. In each such cycle the pad value, the pad enable and the read data are compared with a bench model that follows R3, R4 and R8. A directed case then writes the latch while PWM owns the pad, and later releases the pad. It checks that the pad shows the PWM level until the release and the written latch value after it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W = 8;
    localparam int PIN_W  = 4;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
    } port_state_t;

    typedef struct packed {
        logic val;
        logic oe;
    } pad_drive_t;

    // Read view of the data address: output bits show the latch, input
    // bits show the synchronized pad level, and pinless input bits show 0.
    function automatic logic [PORT_W-1:0] data_view(
        input port_state_t      st,
        input logic [PIN_W-1:0] pad_sync
    );
        logic [PORT_W-1:0] v;
        for (int b = 0; b < PORT_W; b++) begin
            if (st.dir[b])
                v[b] = st.data[b];
            else if (b < PIN_W)
                v[b] = pad_sync[b];
            else
                v[b] = 1'b0;
        end
        return v;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        stage1_q <= async_in;
        stage2_q <= stage1_q;
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [PIN_W-1:0]  pad_sync,
    output port_state_t       st_q,
    output logic [PORT_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR;
    localparam logic [ADDR_W-1:0] DIR_ADDR  = BASE_ADDR + 1'b1;

    reg_sel_e sel;

    always_comb begin
        if (addr == DATA_ADDR)
            sel = SEL_DATA;
        else if (addr == DIR_ADDR)
            sel = SEL_DIR;
        else
            sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_DATA)
                st_q.data <= wr_data;
            if (sel == SEL_DIR)
                st_q.dir <= wr_data;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_data = data_view(st_q, pad_sync);
            SEL_DIR:  rd_data = st_q.dir;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
(
    input  logic [PIN_W-1:0] dir_lo,
    input  logic [PIN_W-1:0] latch_lo,
    input  logic [PIN_W-1:0] pwm_en,
    input  logic [PIN_W-1:0] pwm_out,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);

    for (genvar p = 0; p < PIN_W; p++) begin : g_pad
        pad_drive_t drv;
        always_comb begin
            if (pwm_en[p]) begin
                drv.val = pwm_out[p];
                drv.oe  = 1'b1;
            end else begin
                drv.val = latch_lo[p];
                drv.oe  = dir_lo[p];
            end
        end
        assign pin_out[p] = drv.val;
        assign pin_oe[p]  = drv.oe;
    end

endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port
    import gpio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PIN_W-1:0]  pin_in,
    input  logic [PIN_W-1:0]  pwm_en,
    input  logic [PIN_W-1:0]  pwm_out,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);

    logic [PIN_W-1:0] pad_sync;
    port_state_t      st_q;

    gpio_sync #(.W(PIN_W)) u_sync (
        .clk      (clk),
        .async_in (pin_in),
        .sync_out (pad_sync)
    );

    gpio_regs #(.BASE_ADDR(BASE_ADDR)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pad_sync (pad_sync),
        .st_q     (st_q),
        .rd_data  (rd_data)
    );

    gpio_pinmux u_mux (
        .dir_lo   (st_q.dir[PIN_W-1:0]),
        .latch_lo (st_q.data[PIN_W-1:0]),
        .pwm_en   (pwm_en),
        .pwm_out  (pwm_out),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: rtl/gpio_pwm_port_chk.sv
module gpio_pwm_port_chk
    import gpio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [PORT_W-1:0] wr_data,
    input logic [PORT_W-1:0] rd_data,
    input logic [PIN_W-1:0]  pin_in,
    input logic [PIN_W-1:0]  pwm_en,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  pin_oe,
    input logic [PORT_W-1:0] dir_q,
    input logic [PORT_W-1:0] data_q
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR;
    localparam logic [ADDR_W-1:0] DIR_ADDR  = BASE_ADDR + 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dir_q == '0 && data_q == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == DIR_ADDR) |=> dir_q == $past(wr_data));

    // R2
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != DATA_ADDR && addr != DIR_ADDR)
            |=> ($stable(dir_q) && $stable(data_q)));

    // R3
    input_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & ~pwm_en & ~dir_q[PIN_W-1:0]) == '0);

    // R4
    latch_to_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == DATA_ADDR && pwm_en == '0)
            |=> (pwm_en != '0 || pin_out == $past(wr_data[PIN_W-1:0])));

    // R5
    out_latch_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == DATA_ADDR) |-> ((rd_data ^ data_q) & dir_q) == '0);

    // R6
    pad_sync_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == DATA_ADDR)
            |-> ((rd_data[PIN_W-1:0] ^ $past(pin_in, 2)) & ~dir_q[PIN_W-1:0]) == '0);

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == DATA_ADDR)
            |-> (rd_data[PORT_W-1:PIN_W] & ~dir_q[PORT_W-1:PIN_W]) == '0);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (addr != DATA_ADDR && addr != DIR_ADDR) |-> rd_data == '0);

endmodule

bind gpio_pwm_port gpio_pwm_port_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_in  (pin_in),
    .pwm_en  (pwm_en),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .dir_q   (st_q.dir),
    .data_q  (st_q.data)
);

// File: tb/gpio_pwm_port_bench.sv
module gpio_pwm_port_bench;

    localparam logic [7:0] BASE = 8'h20;
    localparam logic [7:0] A_DATA = BASE;
    localparam logic [7:0] A_DIR  = BASE + 8'h01;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [3:0] pin_in;
    logic [3:0] pwm_en;
    logic [3:0] pwm_out;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_data, m_dir;
    logic [3:0] m_s1, m_s2;

    always #5 clk = ~clk;

    gpio_pwm_port #(.BASE_ADDR(BASE)) u_gpio_pwm_port (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pwm_en(pwm_en), .pwm_out(pwm_out),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        logic [7:0] v;
        if (a == A_DIR) return m_dir;
        if (a != A_DATA) return 8'h00;
        for (int b = 0; b < 8; b++)
            v[b] = m_dir[b] ? m_data[b] : (b < 4 ? m_s2[b] : 1'b0);
        return v;
    endfunction

    function automatic logic [3:0] exp_out();
        return (pwm_en & pwm_out) | (~pwm_en & m_data[3:0]);
    endfunction

    function automatic logic [3:0] exp_oe();
        return pwm_en | m_dir[3:0];
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
        end
    endtask

    // drive one cycle, check combinational outputs, then advance the model
    task automatic step(input logic [7:0] a, input logic we, input logic [7:0] wd,
                        input logic [3:0] pins, input logic [3:0] pe, input logic [3:0] po);
        @(negedge clk);
        addr = a; wr_en = we; wr_data = wd; pin_in = pins; pwm_en = pe; pwm_out = po;
        #1;
        check("R5 R6 R7 R8 R9 R10 read", rd_data, exp_rd(a));
        check("R4 pad value", {4'h0, pin_out}, {4'h0, exp_out()});
        check("R3 pad enable", {4'h0, pin_oe}, {4'h0, exp_oe()});
        @(posedge clk);
        if (we && a == A_DATA) m_data = wd;
        if (we && a == A_DIR)  m_dir  = wd;
        m_s2 = m_s1;
        m_s1 = pins;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; addr = 8'h00; wr_en = 1'b0; wr_data = 8'h00;
        pin_in = 4'h0; pwm_en = 4'h0; pwm_out = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_data = 8'h00; m_dir = 8'h00; m_s1 = 4'h0; m_s2 = 4'h0;

        // R1: cleared state after reset
        #1;
        check("R1 oe after reset", {4'h0, pin_oe}, 8'h00);
        addr = A_DIR; #1;
        check("R1 dir after reset", rd_data, 8'h00);

        // R6: pad level shows after two edges, input pins
        step(A_DATA, 1'b0, 8'h00, 4'hA, 4'h0, 4'h0);
        step(A_DATA, 1'b0, 8'h00, 4'hA, 4'h0, 4'h0);
        step(A_DATA, 1'b0, 8'h00, 4'hA, 4'h0, 4'h0);
        check("R6 synced pad level", rd_data, 8'h0A);

        // R7: upper bits written with direction input read zero
        step(A_DATA, 1'b1, 8'hF5, 4'hA, 4'h0, 4'h0);
        step(A_DATA, 1'b0, 8'h00, 4'hA, 4'h0, 4'h0);
        check("R7 upper input reads zero", rd_data & 8'hF0, 8'h00);

        // R9/R5: all outputs, read latch
        step(A_DIR, 1'b1, 8'hFF, 4'hA, 4'h0, 4'h0);
        step(A_DATA, 1'b0, 8'h00, 4'hA, 4'h0, 4'h0);
        check("R5 latch read", rd_data, 8'hF5);

        // R2: unmapped write ignored, R10 unmapped read zero
        step(8'h7E, 1'b1, 8'h00, 4'hA, 4'h0, 4'h0);
        step(A_DIR, 1'b0, 8'h00, 4'hA, 4'h0, 4'h0);
        check("R2 dir kept after stray write", rd_data, 8'hFF);
        step(A_DATA, 1'b0, 8'h00, 4'hA, 4'h0, 4'h0);
        check("R2 data kept after stray write", rd_data, 8'hF5);

        // R8: PWM on an input pin still reads the pad
        step(A_DIR, 1'b1, 8'hF0, 4'h3, 4'hF, 4'hC);
        step(A_DATA, 1'b0, 8'h00, 4'h3, 4'hF, 4'hC);
        step(A_DATA, 1'b0, 8'h00, 4'h3, 4'hF, 4'hC);
        check("R8 input pin under PWM reads pad", rd_data, 8'hF3);

        // R4 concurrent: latch written while PWM owns pad, then released
        step(A_DATA, 1'b1, 8'hF9, 4'h3, 4'hF, 4'hC);
        step(A_DATA, 1'b0, 8'h00, 4'h3, 4'hF, 4'hC);
        check("R4 PWM wins over new latch", {4'h0, pin_out}, 8'h0C);
        step(A_DIR, 1'b1, 8'h0F, 4'h3, 4'h0, 4'hC);
        step(A_DATA, 1'b0, 8'h00, 4'h3, 4'h0, 4'hC);
        check("R4 latch after release", {4'h0, pin_out}, 8'h09);

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            case ($urandom % 5)
                0, 1: a = A_DATA;
                2, 3: a = A_DIR;
                default: a = 8'($urandom);
            endcase
            step(a, 1'($urandom), 8'($urandom), 4'($urandom),
                 4'($urandom), 4'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule